// File: doc/BRIEF.md
# Floating-Point Exception Flag Recorder

This block sits at the retirement end of a floating-point datapath. When an operation finishes, the datapath pulses `op_done` and presents the five IEEE exception flags it raised, together with the current value of the floating-point status register. One cycle later the block returns the rewritten status register and says how the operation retires. Either the program counter moves past the instruction (`pc_adv`), or a trap must be taken (`trap_req`). The rounding logic, the detection of exceptions and the trap handler all live elsewhere.

A trap is needed when any raised flag is also enabled in the register's trap-enable field. In that case the enabled flags are reduced to a single bit by a fixed priority, and the accrued record is left alone. Otherwise every raised flag is written to the current field and also ORed into the accrued field.

A small state machine holds the result of the last cycle. `ST_IDLE` means no operation retired. `ST_ADV` means the last operation retires and the PC moves on. `ST_TRAP` means the last operation traps. From every state the machine follows the same three transitions on each clock. It goes to `ST_IDLE` when `op_done` is low. It goes to `ST_TRAP` when `op_done` is high and an enabled flag is raised. It goes to `ST_ADV` when `op_done` is high and no enabled flag is raised. Synchronous reset forces `ST_IDLE`.

Top module: `fp_excflag_rec`

## Requirements
- R1: While `rst` is sampled high at a clock edge, after that edge `sr_out` is zero and `sr_out_vld`, `trap_req` and `pc_adv` are low.
- R2: `sr_out_vld` is high in exactly the cycle after each cycle in which `op_done` was sampled high, so operations on consecutive cycles each produce one result.
- R3: A trap is taken when `raised & sr_in[27:23]` (trap-enable field) is nonzero; the result then shows `trap_req`=1 and `pc_adv`=0.
- R4: When no enabled flag is raised, the result shows `pc_adv`=1 and `trap_req`=0.
- R5: On a trap, the current field `sr_out[4:0]` holds only the highest-priority bit of `raised & enables`. The flag bits are invalid=bit4, overflow=bit3, underflow=bit2, divide-by-zero=bit1 and inexact=bit0, and a higher bit index has priority.
- R6: Without a trap, `sr_out[4:0]` equals `raised` (it replaces the old value), and the accrued field `sr_out[9:5]` equals `sr_in[9:5] | raised`.
- R7: On a trap, the accrued field `sr_out[9:5]` equals `sr_in[9:5]`, and the trap-type field `sr_out[16:14]` is 3'b001.
- R8: Without a trap, `sr_out[16:14]` equals `sr_in[16:14]`. In every result, all bits outside the current, accrued and trap-type fields (the trap-enable field included) are copied from `sr_in`.
- R9: An operation with `raised`=0 clears `sr_out[4:0]` and gives `pc_adv`=1.
- R10: In a cycle after `op_done` was sampled low, `sr_out_vld`, `trap_req` and `pc_adv` are low, and `sr_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_done | input | 1 | An FP operation completes this cycle |
| raised | input | 5 | Exception flags raised by the operation |
| sr_in | input | 32 | Current floating-point status register |
| sr_out | output | 32 | Rewritten status register, held between results |
| sr_out_vld | output | 1 | `sr_out` carries a new result this cycle |
| trap_req | output | 1 | The reported operation must trap |
| pc_adv | output | 1 | The reported operation retires; advance the PC |

## Verification
Two things can happen in the same cycle. The outcome of one operation is reported while the next operation is accepted, and that next operation may take the opposite path (a trap following an accruing retirement, or the reverse). The bench drives runs of `op_done` on consecutive cycles with trap-enable masks that alternate between empty, partial and full. It also inserts gaps between operations. On every clock it compares the held register and the retirement strobes against a behavioural model. That comparison shows whether the second operation's result is built from its own `sr_in` and not from the first one's rewritten register, and whether a trap ever leaks into the accrued field.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADV  = 2'd1,
        ST_TRAP = 2'd2
    } fx_state_e;

endpackage

// File: rtl/fx_trap_decide.sv
module fx_trap_decide #(
    parameter int FLAG_W = 5
) (
    input  logic [FLAG_W-1:0] raised,
    input  logic [FLAG_W-1:0] enables,
    output logic [FLAG_W-1:0] masked,
    output logic              trap
);
    always_comb begin
        masked = raised & enables;
        trap   = |masked;
    end
endmodule

// File: rtl/fx_prio_pick.sv
module fx_prio_pick #(
    parameter int FLAG_W = 5
) (
    input  logic [FLAG_W-1:0] vec_in,
    output logic [FLAG_W-1:0] vec_out
);
    // Highest index wins: a bit survives only if no higher bit is set.
    genvar gi;
    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_keep
            if (gi == FLAG_W - 1) begin : g_top
                assign vec_out[gi] = vec_in[gi];
            end else begin : g_low
                assign vec_out[gi] = vec_in[gi] & ~(|vec_in[FLAG_W-1:gi+1]);
            end
        end
    endgenerate
endmodule

// File: rtl/fx_sr_merge.sv
module fx_sr_merge #(
    parameter int SR_W     = 32,
    parameter int FLAG_W   = 5,
    parameter int CUR_LSB  = 0,
    parameter int ACC_LSB  = 5,
    parameter int TT_LSB   = 14,
    parameter int TT_W     = 3,
    parameter int TT_IEEE  = 1
) (
    input  logic [SR_W-1:0]   sr_in,
    input  logic [FLAG_W-1:0] raised,
    input  logic [FLAG_W-1:0] picked,
    input  logic              trap,
    output logic [SR_W-1:0]   sr_next
);
    localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_IEEE);

    always_comb begin
        sr_next = sr_in;
        if (trap) begin
            sr_next[CUR_LSB +: FLAG_W] = picked;
            sr_next[TT_LSB +: TT_W]    = TT_CODE;
        end else begin
            sr_next[CUR_LSB +: FLAG_W] = raised;
            sr_next[ACC_LSB +: FLAG_W] = sr_in[ACC_LSB +: FLAG_W] | raised;
        end
    end
endmodule

// File: rtl/fp_excflag_rec.sv
module fp_excflag_rec #(
    parameter int SR_W     = 32,
    parameter int FLAG_W   = 5,
    parameter int EN_LSB   = 23,
    parameter int ACC_LSB  = 5,
    parameter int CUR_LSB  = 0,
    parameter int TT_LSB   = 14,
    parameter int TT_W     = 3,
    parameter int TT_IEEE  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_done,
    input  logic [FLAG_W-1:0] raised,
    input  logic [SR_W-1:0]   sr_in,
    output logic [SR_W-1:0]   sr_out,
    output logic              sr_out_vld,
    output logic              trap_req,
    output logic              pc_adv
);
    import fpx_pkg::*;

    fx_state_e         state_q, state_nx;
    logic [FLAG_W-1:0] masked, picked;
    logic              trap;
    logic [SR_W-1:0]   sr_next, sr_q;

    fx_trap_decide #(.FLAG_W(FLAG_W)) decide_i (
        .raised  (raised),
        .enables (sr_in[EN_LSB +: FLAG_W]),
        .masked  (masked),
        .trap    (trap)
    );

    fx_prio_pick #(.FLAG_W(FLAG_W)) pick_i (
        .vec_in  (masked),
        .vec_out (picked)
    );

    fx_sr_merge #(
        .SR_W(SR_W), .FLAG_W(FLAG_W), .CUR_LSB(CUR_LSB), .ACC_LSB(ACC_LSB),
        .TT_LSB(TT_LSB), .TT_W(TT_W), .TT_IEEE(TT_IEEE)
    ) merge_i (
        .sr_in   (sr_in),
        .raised  (raised),
        .picked  (picked),
        .trap    (trap),
        .sr_next (sr_next)
    );

    // Next state: the same three transitions from every state.
    always_comb begin
        state_nx = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ADV, ST_TRAP: begin
                if (!op_done)  state_nx = ST_IDLE;
                else if (trap) state_nx = ST_TRAP;
                else           state_nx = ST_ADV;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    // Held status register.
    always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (op_done) sr_q <= sr_next;
    end

    // Outputs.
    always_comb begin
        sr_out     = sr_q;
        sr_out_vld = 1'b0;
        trap_req   = 1'b0;
        pc_adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADV: begin
                sr_out_vld = 1'b1;
                pc_adv     = 1'b1;
            end
            ST_TRAP: begin
                sr_out_vld = 1'b1;
                trap_req   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fp_excflag_rec_chk.sv
module fp_excflag_rec_chk #(
    parameter int SR_W     = 32,
    parameter int FLAG_W   = 5,
    parameter int ACC_LSB  = 5,
    parameter int CUR_LSB  = 0,
    parameter int TT_LSB   = 14,
    parameter int TT_W     = 3,
    parameter int TT_IEEE  = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              op_done,
    input logic [FLAG_W-1:0] raised,
    input logic [SR_W-1:0]   sr_in,
    input logic [SR_W-1:0]   sr_out,
    input logic              sr_out_vld,
    input logic              trap_req,
    input logic              pc_adv
);
    localparam logic [SR_W-1:0] FLD   = {{(SR_W-FLAG_W){1'b0}}, {FLAG_W{1'b1}}};
    localparam logic [SR_W-1:0] TTF   = {{(SR_W-TT_W){1'b0}}, {TT_W{1'b1}}};
    localparam logic [SR_W-1:0] M_CUR = FLD << CUR_LSB;
    localparam logic [SR_W-1:0] M_ACC = FLD << ACC_LSB;
    localparam logic [SR_W-1:0] M_TT  = TTF << TT_LSB;
    localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_IEEE);

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        op_done |=> sr_out_vld) else $error("op_done not followed by result"); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        sr_out_vld |-> (trap_req ^ pc_adv)) else $error("outcome not exclusive"); // R3
    AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> ($countones(sr_out[CUR_LSB +: FLAG_W]) == 1)) else $error("trap flag not single"); // R5
    AST_NOTRAP_CUR: assert property (@(posedge clk) disable iff (rst)
        op_done |=> (pc_adv |-> (sr_out[CUR_LSB +: FLAG_W] == $past(raised)))) else $error("current field wrong"); // R6
    AST_TRAP_ACC: assert property (@(posedge clk) disable iff (rst)
        op_done |=> (trap_req |-> ((sr_out & ~(M_CUR | M_TT)) == ($past(sr_in) & ~(M_CUR | M_TT)))))
        else $error("trap touched accrued/other bits"); // R7
    AST_TRAP_TYPE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (sr_out[TT_LSB +: TT_W] == TT_CODE)) else $error("trap type wrong"); // R7
    AST_PASS_BITS: assert property (@(posedge clk) disable iff (rst)
        op_done |=> (pc_adv |-> ((sr_out & ~(M_CUR | M_ACC)) == ($past(sr_in) & ~(M_CUR | M_ACC)))))
        else $error("pass-through bits changed"); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_done |=> (!sr_out_vld && !trap_req && !pc_adv && $stable(sr_out))) else $error("idle not quiet"); // R10
endmodule

bind fp_excflag_rec fp_excflag_rec_chk #(
    .SR_W(SR_W), .FLAG_W(FLAG_W), .ACC_LSB(ACC_LSB), .CUR_LSB(CUR_LSB),
    .TT_LSB(TT_LSB), .TT_W(TT_W), .TT_IEEE(TT_IEEE)
) chk_i (
    .clk(clk), .rst(rst), .op_done(op_done), .raised(raised), .sr_in(sr_in),
    .sr_out(sr_out), .sr_out_vld(sr_out_vld), .trap_req(trap_req), .pc_adv(pc_adv)
);

// File: tb/fp_excflag_rec_tb_top.sv
module fp_excflag_rec_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_done = 1'b0;
    logic [4:0]  raised = '0;
    logic [31:0] sr_in = '0;
    logic [31:0] sr_out;
    logic        sr_out_vld, trap_req, pc_adv;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    // model state: expected outputs after the next edge
    logic [31:0] e_sr  = '0;
    logic        e_vld = 1'b0, e_trap = 1'b0, e_adv = 1'b0;
    int          ctx   = 0;   // 0 reset, 1 idle, 2 advance, 3 trap
    bit          zero_op = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fp_excflag_rec dut_i (
        .clk(clk), .rst(rst), .op_done(op_done), .raised(raised), .sr_in(sr_in),
        .sr_out(sr_out), .sr_out_vld(sr_out_vld), .trap_req(trap_req), .pc_adv(pc_adv)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tg(input string rst_t, input string idle_t, input string adv_t, input string trap_t);
        case (ctx)
            0: return rst_t;
            1: return idle_t;
            2: return adv_t;
            default: return trap_t;
        endcase
    endfunction

    task automatic compare_all();
        chk(sr_out_vld === e_vld, tg("R1", "R10", "R2", "R2"), 32'(sr_out_vld), 32'(e_vld));
        chk(trap_req === e_trap, tg("R1", "R10", "R4", "R3"), 32'(trap_req), 32'(e_trap));
        chk(pc_adv === e_adv, tg("R1", "R10", zero_op ? "R9" : "R4", "R3"), 32'(pc_adv), 32'(e_adv));
        chk(sr_out[4:0] === e_sr[4:0], tg("R1", "R10", zero_op ? "R9" : "R6", "R5"),
            32'(sr_out[4:0]), 32'(e_sr[4:0]));
        chk(sr_out[9:5] === e_sr[9:5], tg("R1", "R10", "R6", "R7"), 32'(sr_out[9:5]), 32'(e_sr[9:5]));
        chk(sr_out[16:14] === e_sr[16:14], tg("R1", "R10", "R8", "R7"), 32'(sr_out[16:14]), 32'(e_sr[16:14]));
        chk((sr_out & 32'hFFFE_3C00) === (e_sr & 32'hFFFE_3C00), tg("R1", "R10", "R8", "R8"),
            sr_out, e_sr);
    endtask

    // One cycle: check what the last edge produced, then drive and predict.
    task automatic step(input bit r, input bit d, input logic [4:0] fl, input logic [31:0] s);
        logic [4:0] en, hit, one;
        bit got;
        @(negedge clk);
        compare_all();
        rst = r; op_done = d; raised = fl; sr_in = s;
        if (r) begin
            e_sr = '0; e_vld = 0; e_trap = 0; e_adv = 0; ctx = 0; zero_op = 0;
        end else if (d) begin
            en  = s[27:23];
            hit = fl & en;
            e_vld = 1;
            zero_op = (fl == 5'd0);
            e_sr = s;
            if (hit != 0) begin
                one = '0; got = 0;
                for (int i = 4; i >= 0; i--) begin
                    if (!got && hit[i]) begin one[i] = 1'b1; got = 1; end
                end
                e_sr[4:0] = one;
                e_sr[16:14] = 3'd1;
                e_trap = 1; e_adv = 0; ctx = 3;
            end else begin
                e_sr[4:0] = fl;
                e_sr[9:5] = s[9:5] | fl;
                e_trap = 0; e_adv = 1; ctx = 2;
            end
        end else begin
            e_vld = 0; e_trap = 0; e_adv = 0; ctx = 1; zero_op = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset, with junk on the inputs
        step(1, 1, 5'h1F, 32'hFFFF_FFFF);
        step(1, 0, 5'h00, 32'h0);
        step(0, 0, 5'h00, 32'h0);
        // R9: no flags raised clears old current field
        step(0, 1, 5'h00, 32'h0000_001F);
        // R6: flags, no enables; accrue onto existing accrued bits
        step(0, 1, 5'h05, 32'h0000_0120);
        // R3/R5: single enabled flag
        step(0, 1, 5'h08, 32'h0400_0000);
        // R5: several enabled, invalid wins over all
        step(0, 1, 5'h1F, 32'h0F80_03E0);
        // R5: overflow beats underflow, invalid not enabled
        step(0, 1, 5'h1E, 32'h0700_0000);
        // R5: inexact only kept when alone
        step(0, 1, 5'h01, 32'h0080_0000);
        // R4/R8: raised but disabled flag, trap-type preserved
        step(0, 1, 5'h10, 32'h0780_C000);
        // R10: gap holds the register
        step(0, 0, 5'h1F, 32'hFFFF_FFFF);
        step(0, 0, 5'h00, 32'h0);
        // R2: back-to-back, alternating trap / accrue
        step(0, 1, 5'h03, 32'h0100_0000);
        step(0, 1, 5'h03, 32'h0000_0040);
        step(0, 1, 5'h14, 32'h0F80_0000);
        step(0, 1, 5'h00, 32'h0F80_001F);
        // random traffic
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] s;
            s = $urandom;
            case ($urandom % 3)
                0: s[27:23] = 5'd0;
                1: s[27:23] = 5'h1F;
                default: ;
            endcase
            step(($urandom % 97) == 0, ($urandom % 4) != 0, 5'($urandom), s);
        end
        step(0, 0, 5'h0, 32'h0);
        step(0, 0, 5'h0, 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule